// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block merges a set of interrupt source lines into one request line for a processor. Each line can be configured before synthesis in one of two ways. A level line is copied into its status bit while the line is asserted. A latched line sets its status bit and keeps it set until software clears it. A status bit counts as pending only while its enable bit is also set. The block encodes the lowest-numbered pending line as a vector number, so the handler can find its source with one read.

Software reaches the block through a word-addressed register port with separate read and write strobes. Writes take effect at the clock edge. Read data appears one cycle after the read strobe. Enable bits can be changed in three ways: a direct store, a set-only write, or a clear-only write. The set-only and clear-only writes let software change single bits without a read-modify-write. A two-bit master control word gates two things separately: the request output, and the sampling of the source lines.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After a synchronous reset, status, enable and master control are zero, the request output is low, and the vector reads 0xFFFFFFFF.
- R2: The word index is the byte address shifted right by 2. The indices are: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. Read data appears on the clock edge that samples the read strobe. Indices 3, 4 and 5 read as zero.
- R3: Pending always equals status AND enable. A write to index 1 has no effect.
- R4: The vector is the index of the lowest set pending bit, or 0xFFFFFFFF when no bit is pending. A write to index 6 has no effect.
- R5: The request output is high exactly when master bit 0 is set, master bit 1 is set, and at least one pending bit is set.
- R6: A write to index 3 clears every status bit whose data bit is 1 and leaves the other status bits alone.
- R7: A write to index 4 ORs the data into enable. A write to index 5 clears each enable bit whose data bit is 1. A write to index 2 stores the data into enable.
- R8: While master bit 1 is clear, the source lines have no effect on status.
- R9: While master bit 1 is set, a level line's status bit equals the line value from the previous cycle. A latched line sets its status bit and keeps it set after the line falls.
- R10: A write to index 0 stores the data into status. Level lines then overwrite their bits if sampling is on. A write to index 7 stores data bits [1:0] into master.
- R11: If a latched line is asserted in the same cycle that its bit is acknowledged, the status bit stays set.
- R12: Word indices 8 and above read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, registered |
| src_in | input | NUM_SRC (32) | Interrupt source lines |
| irq_out | output | 1 | Request to the processor |

## Verification
The bench runs the lower 16 lines as level lines and the upper 16 as latched lines. This exposes two kinds of error. A design that latches every line would keep a level bit set after its line falls. A design that follows every line would lose a latched bit after a one-cycle pulse.

The bench asserts a latched line in the same cycle as its acknowledge. A design that lets the acknowledge win would drop that interrupt. With sampling off, the bench toggles the source lines and writes status directly. A design that ignores the sampling gate would capture the lines, and a design that blocks the direct store would hold on to stale status.

The bench also sets the master bits one at a time. A design that uses only one of the two bits would raise the request line while the other bit is clear. Writes to indices 1, 6, 9 and 15 must leave the state unchanged, so a design that stores those writes or decodes only the low address bits would show changed state on read-back.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [2:0] {
        IDX_STATUS = 3'd0,
        IDX_PEND   = 3'd1,
        IDX_ENABLE = 3'd2,
        IDX_ACK    = 3'd3,
        IDX_SETEN  = 3'd4,
        IDX_CLREN  = 3'd5,
        IDX_VECTOR = 3'd6,
        IDX_MASTER = 3'd7
    } reg_idx_e;

    // Master control word: bit 1 gates sampling, bit 0 gates the output.
    typedef struct packed {
        logic sample_en;
        logic out_en;
    } master_t;

    // One-hot write strobes produced by the decoder.
    typedef struct packed {
        logic status;
        logic enable;
        logic ack;
        logic seten;
        logic clren;
        logic master;
    } wr_strobe_t;

    function automatic wr_strobe_t strobe_of(input logic wr, input logic in_range,
                                             input reg_idx_e idx);
        wr_strobe_t s;
        s = '0;
        if (wr && in_range) begin
            case (idx)
                IDX_STATUS: s.status = 1'b1;
                IDX_ENABLE: s.enable = 1'b1;
                IDX_ACK:    s.ack    = 1'b1;
                IDX_SETEN:  s.seten  = 1'b1;
                IDX_CLREN:  s.clren  = 1'b1;
                IDX_MASTER: s.master = 1'b1;
                default:    s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_idx_e          idx,
    output logic              in_range,
    output wr_strobe_t        strobe
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word;

    assign word     = bus_addr[ADDR_W-1:2];
    assign in_range = (word < IDX_W'(8));
    assign idx      = reg_idx_e'(word[2:0]);

    always_comb strobe = strobe_of(bus_wr, in_range, idx);

endmodule

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int               NUM_SRC    = 32,
    parameter logic [NUM_SRC-1:0] LATCH_MASK = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sample_en,
    input  logic               wr_status,
    input  logic               wr_ack,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] src,
    output logic [NUM_SRC-1:0] status
);
    logic [NUM_SRC-1:0] status_d;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic base;
        always_comb begin
            base = wr_status ? wdata[i] : status[i];
            if (wr_ack && wdata[i]) base = 1'b0;
        end
        if (LATCH_MASK[i]) begin : g_latch
            // an asserted line outranks a same-cycle acknowledge
            assign status_d[i] = sample_en ? (base | src[i]) : base;

            // R11
            latch_win_chk: assert property (@(posedge clk) disable iff (rst)
                (sample_en && src[i]) |=> status[i]);
        end else begin : g_level
            assign status_d[i] = sample_en ? src[i] : base;

            // R9
            level_follow_chk: assert property (@(posedge clk) disable iff (rst)
                sample_en |=> (status[i] == $past(src[i])));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= status_d;
    end

    // R8
    sample_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!sample_en && !wr_status && !wr_ack) |=> $stable(status));

endmodule

// File: rtl/irqc_lowest.sv
module irqc_lowest #(
    parameter int NUM_SRC = 32,
    parameter int OUT_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend,
    output logic [OUT_W-1:0]   vec,
    output logic               any
);
    localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    always_comb begin
        vec = '1;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) vec = OUT_W'(i);
        end
    end

    assign any = |pend;

    // R4
    vec_hit_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> pend[vec[IW-1:0]]);

    // R4
    vec_none_chk: assert property (@(posedge clk) disable iff (rst)
        !any |-> (&vec));

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irqc_pkg::*;
#(
    parameter int                 NUM_SRC    = 32,
    parameter int                 DATA_W     = 32,
    parameter int                 ADDR_W     = 8,
    parameter logic [NUM_SRC-1:0] LATCH_MASK = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               irq_out
);
    reg_idx_e           idx;
    logic               in_range;
    wr_strobe_t         stb;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] wbits;
    logic [DATA_W-1:0]  vec;
    logic               any_pend;
    master_t            mstr_q;
    logic [DATA_W-1:0]  status_x, enable_x, pend_x, rd_d;

    assign wbits = bus_wdata[NUM_SRC-1:0];

    irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .idx      (idx),
        .in_range (in_range),
        .strobe   (stb)
    );

    irqc_capture #(.NUM_SRC(NUM_SRC), .LATCH_MASK(LATCH_MASK)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .sample_en (mstr_q.sample_en),
        .wr_status (stb.status),
        .wr_ack    (stb.ack),
        .wdata     (wbits),
        .src       (src_in),
        .status    (status)
    );

    assign pend = status & enable_q;

    irqc_lowest #(.NUM_SRC(NUM_SRC), .OUT_W(DATA_W)) u_low (
        .clk  (clk),
        .rst  (rst),
        .pend (pend),
        .vec  (vec),
        .any  (any_pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            mstr_q   <= '0;
        end else begin
            if (stb.enable) enable_q <= wbits;
            if (stb.seten)  enable_q <= enable_q | wbits;
            if (stb.clren)  enable_q <= enable_q & ~wbits;
            if (stb.master) mstr_q   <= master_t'(bus_wdata[1:0]);
        end
    end

    assign irq_out = mstr_q.out_en && mstr_q.sample_en && any_pend;

    always_comb begin
        status_x = '0; status_x[NUM_SRC-1:0] = status;
        enable_x = '0; enable_x[NUM_SRC-1:0] = enable_q;
        pend_x   = '0; pend_x[NUM_SRC-1:0]   = pend;
        rd_d     = '0;
        if (in_range) begin
            case (idx)
                IDX_STATUS: rd_d = status_x;
                IDX_PEND:   rd_d = pend_x;
                IDX_ENABLE: rd_d = enable_x;
                IDX_VECTOR: rd_d = vec;
                IDX_MASTER: rd_d = DATA_W'(mstr_q);
                default:    rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_d;
    end

    // R7
    seten_chk: assert property (@(posedge clk) disable iff (rst)
        stb.seten |=> ((enable_q & $past(wbits)) == $past(wbits)));

    // R7
    clren_chk: assert property (@(posedge clk) disable iff (rst)
        stb.clren |=> ((enable_q & $past(wbits)) == '0));

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stb.ack && !mstr_q.sample_en) |=> ((status & $past(wbits)) == '0));

    // R12
    out_range_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !in_range) |=> ($stable(enable_q) && $stable(mstr_q)));

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (mstr_q == master_t'(2'b11)));

endmodule

// File: tb/tb_irq_vec_ctrl.sv
module tb_irq_vec_ctrl;

    localparam logic [31:0] LATCH = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_in = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];

    // reference state
    logic [31:0] m_stat = '0, m_en = '0;
    logic [1:0]  m_mer = '0;
    logic [31:0] src_drv = '0;

    always #4 clk = ~clk;

    irq_vec_ctrl #(.NUM_SRC(32), .DATA_W(32), .ADDR_W(8), .LATCH_MASK(LATCH)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in), .irq_out(irq_out)
    );

    function automatic logic [31:0] m_vec();
        for (int i = 0; i < 32; i++) if (m_stat[i] & m_en[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a[7:2])
            6'd0: return m_stat;
            6'd1: return m_stat & m_en;
            6'd2: return m_en;
            6'd6: return m_vec();
            6'd7: return {30'b0, m_mer};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_irq();
        return (m_mer == 2'b11) && ((m_stat & m_en) != 0);
    endfunction

    task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                        input logic [31:0] d, input string tag);
        exp_t e;
        logic [31:0] ns, ne;
        logic [1:0]  nm;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; src_in = src_drv;
        if (rd) begin
            e.val = m_read(a); e.tag = tag;
            q.push_back(e);
        end
        @(posedge clk);
        ns = m_stat; ne = m_en; nm = m_mer;
        if (wr) begin
            case (a[7:2])
                6'd0: ns = d;
                6'd2: ne = d;
                6'd3: ns = ns & ~d;
                6'd4: ne = ne | d;
                6'd5: ne = ne & ~d;
                6'd7: nm = d[1:0];
                default: ;
            endcase
        end
        if (m_mer[1]) ns = (ns & LATCH) | src_drv;
        m_stat = ns; m_en = ne; m_mer = nm;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b0, a, d, tag);
    endtask

    task automatic rd_reg(input logic [7:0] a, input string tag);
        step(1'b0, 1'b1, a, 32'h0, tag);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 8'h0, 32'h0, "");
    endtask

    // monitor: scoreboard pop and request line compare
    always @(posedge clk) begin
        logic was_rd;
        logic live;
        exp_t e;
        was_rd = bus_rd;
        live = !rst;
        #2;
        if (live && was_rd && q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (bus_rdata !== e.val) begin
                errors++;
                $display("FAIL %s read addr %h: actual %h expected %h", e.tag, bus_addr,
                         bus_rdata, e.val);
            end
        end
        if (live) begin
            checks++;
            if (irq_out !== m_irq()) begin
                errors++;
                $display("FAIL R5 irq_out: actual %b expected %b", irq_out, m_irq());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        rd_reg(8'h00, "R1");
        rd_reg(8'h08, "R1");
        rd_reg(8'h18, "R1");
        rd_reg(8'h1C, "R1");
        rd_reg(8'h04, "R1");
        // R10 master store
        wr_reg(8'h1C, 32'hFFFF_FFFF, "R10");
        rd_reg(8'h1C, "R10");
        // R7 enable writes
        wr_reg(8'h10, 32'h0010_0030, "R7");
        rd_reg(8'h08, "R7");
        wr_reg(8'h14, 32'h0000_0020, "R7");
        rd_reg(8'h08, "R7");
        // R2 action registers read zero
        rd_reg(8'h0C, "R2");
        rd_reg(8'h10, "R2");
        rd_reg(8'h14, "R2");
        // R9 level line
        src_drv = 32'h0000_0010;
        idle();
        rd_reg(8'h00, "R9");
        rd_reg(8'h04, "R3");
        rd_reg(8'h18, "R4");
        src_drv = 32'h0;
        idle();
        rd_reg(8'h00, "R9");
        // R9 latched line pulse
        src_drv = 32'h0010_0000;
        idle();
        src_drv = 32'h0;
        idle();
        rd_reg(8'h00, "R9");
        rd_reg(8'h18, "R4");
        src_drv = 32'h0000_0010;
        idle();
        rd_reg(8'h18, "R4");
        src_drv = 32'h0;
        idle();
        // R6 acknowledge
        wr_reg(8'h0C, 32'h0010_0000, "R6");
        rd_reg(8'h00, "R6");
        rd_reg(8'h18, "R4");
        // R11 assertion beats acknowledge
        src_drv = 32'h0010_0000;
        wr_reg(8'h0C, 32'h0010_0000, "R11");
        src_drv = 32'h0;
        rd_reg(8'h00, "R11");
        wr_reg(8'h0C, 32'h0010_0000, "R6");
        rd_reg(8'h00, "R6");
        // R8 sampling off
        wr_reg(8'h1C, 32'h1, "R8");
        src_drv = 32'h0010_0010;
        idle();
        rd_reg(8'h00, "R8");
        // R10 direct status write, output gated by bit 1
        wr_reg(8'h00, 32'h0000_0011, "R10");
        rd_reg(8'h00, "R10");
        rd_reg(8'h04, "R3");
        // sampling on: level follows, latched captures
        wr_reg(8'h1C, 32'h3, "R5");
        idle();
        rd_reg(8'h00, "R9");
        wr_reg(8'h1C, 32'h2, "R5");
        rd_reg(8'h04, "R5");
        src_drv = 32'h0;
        // R12 out of range
        wr_reg(8'h24, 32'hFFFF_FFFF, "R12");
        wr_reg(8'h3C, 32'hFFFF_FFFF, "R12");
        rd_reg(8'h24, "R12");
        rd_reg(8'h08, "R12");
        rd_reg(8'h1C, "R12");
        // R3 / R4 derived registers ignore writes
        wr_reg(8'h04, 32'hFFFF_FFFF, "R3");
        rd_reg(8'h04, "R3");
        wr_reg(8'h18, 32'h0, "R4");
        rd_reg(8'h18, "R4");
        wr_reg(8'h1C, 32'h3, "R5");
        rd_reg(8'h18, "R4");
        idle();
        idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule